// File: doc/BRIEF.md
# Quarter-Rate Four-Tap Transmit Equalizer

This block is the digital model of a transmit serializer with a feed-forward equalizer in front of the line driver. Four data lanes arrive in parallel, each at one quarter of the serial bit rate. A 4:2 stage turns them into two half-rate streams. A 2:1 stage then turns those into one full-rate bit stream. The half-rate step is timed by a divide-by-two of the full-rate clock. For every serial bit the equalizer produces a signed output code. The code is the sum of four weighted terms: the following bit (precursor), the present bit (main), the bit before (first postcursor) and the bit two before (second postcursor).

Each tap has a 6-bit magnitude and an inversion flag. A data bit counts as +1 when it is logic 1 and as -1 when it is logic 0. The inversion flag is XORed with the data bit before the magnitude is added or subtracted. A second tap with negative weight gives the classic de-emphasis shape. The output is large when consecutive bits differ and small when they repeat. The tap settings and a power-down flag are written through a three-wire serial port and take effect together on a load strobe. Everything runs on the full-rate clock.

Top module: `ffe_tx_serializer`

## Requirements
- R1: After the synchronous active-low reset, the main tap is +63 (inversion flag 0) and the other three taps are 0. Power-down is off. The output code is 0 while reset is held.
- R2: The lanes are sampled on the first clock edge after reset or power-down is released, and then on every fourth edge. Within one sampled group, lane 0 is sent first, then lane 1, lane 2 and lane 3. The code whose main bit is serial bit n of the stream appears after edge 4+n, counted from the first sampling edge as edge 0.
- R3: The code for serial bit n combines bit n+1 on the precursor tap, bit n on the main tap, bit n-1 on the first postcursor and bit n-2 on the second postcursor.
- R4: Each tap adds +magnitude when (data bit XOR inversion flag) is 1, and adds -magnitude otherwise.
- R5: With only a main tap M and a first postcursor P that has its inversion flag set, the code magnitude is M-P when the bit repeats the previous bit and M+P when it differs.
- R6: The serial port shifts 29 bits, MSB first, one bit per clock while the shift input is high. In the word, bit 28 is power-down. Bits 27:21 hold the precursor, 20:14 the main tap, 13:7 the first postcursor and 6:0 the second postcursor. Each 7-bit field is {inversion flag, magnitude[5:0]}. The shifted word has no effect on the output until the load strobe. On the load strobe all fields are applied together.
- R7: While power-down is active, the output code is 0 and the serializer and history are held cleared. After release, the block restarts exactly as after reset (R2, R8).
- R8: After reset or power-down release, the output stays 0 until the history holds valid bits. The first code that can be nonzero is the one for serial bit 2, after edge 6.
- R9: The output is a 9-bit two's-complement code. With all four taps at +63 it reaches +252 for a stream of ones and -252 for a stream of zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_i | input | 4 | Quarter-rate data lanes; lane 0 is sent first |
| cfg_shift_i | input | 1 | Shift enable for the configuration port |
| cfg_sdi_i | input | 1 | Configuration serial data, MSB first |
| cfg_load_i | input | 1 | Applies the shifted word to the active settings |
| eq_code_o | output | 9 | Signed equalized output code, one per bit time |

## Verification
The assertions assume a few things about the inputs. The lanes hold steady across the edge on which a group is sampled. Shift and load are never high on the same edge. The first sampling edge after a restart is the one that follows the release of reset or of power-down. The stimulus meets these by changing lanes only on falling edges and only every fourth cycle from a restart. It pulses load on its own after the 29 shift cycles. It restarts the pipeline before each new tap set by loading power-down and then clearing it. One test keeps the lanes at all ones while a word is shifted in without a load, so any early effect of the shift would show up in the output code.

// File: rtl/ffe_tx_pkg.sv
// Package: shared constants and types for the quarter-rate transmit equalizer.
// Assumes four taps ordered precursor, main, first postcursor, second postcursor.
package ffe_tx_pkg;

    localparam int N_LANES  = 4;
    localparam int N_TAPS   = 4;
    localparam int MAG_W    = 6;
    localparam int CODE_W   = 9;
    localparam int FIELD_W  = MAG_W + 1;
    localparam int CFG_W    = N_TAPS * FIELD_W + 1;

    localparam int TAP_PRE   = 0;
    localparam int TAP_MAIN  = 1;
    localparam int TAP_POST1 = 2;
    localparam int TAP_POST2 = 3;

    // Reset word: main tap at full positive magnitude, all else zero.
    localparam logic [CFG_W-1:0] CFG_DEFAULT =
        CFG_W'((1 << MAG_W) - 1) << ((N_TAPS - 1 - TAP_MAIN) * FIELD_W);

    typedef struct packed {
        logic             inv;
        logic [MAG_W-1:0] mag;
    } tap_w_t;

endpackage

// File: rtl/ffe_cfg_port.sv
// Module: three-wire configuration shifter with an applied-settings register.
// Shifts one bit per enabled clock, MSB first. The load strobe copies the shifted
// word into the active register. Assumes shift and load are never high together.
module ffe_cfg_port
    import ffe_tx_pkg::*;
#(
    parameter int NT = N_TAPS,
    parameter int FW = FIELD_W,
    localparam int W = NT * FW + 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   shift_en,
    input  logic   sdi,
    input  logic   load,
    output tap_w_t taps   [NT],
    output logic   pd
);

    logic [W-1:0] sh_q;
    logic [W-1:0] act_q;

    // Shift register: collects the incoming word MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)        sh_q <= '0;
        else if (shift_en) sh_q <= {sh_q[W-2:0], sdi};
    end

    // Active settings: replaced as a whole on the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    act_q <= CFG_DEFAULT;
        else if (load) act_q <= sh_q;
    end

    assign pd = act_q[W-1];

    generate
        for (genvar t = 0; t < NT; t++) begin : g_field
            assign taps[t] = act_q[W-2-t*FW -: FW];
        end
    endgenerate

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_q));

    // R6
    cfg_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> act_q == $past(sh_q));

endmodule

// File: rtl/ffe_lane_serializer.sv
// Module: two-stage 4:2:1 serializer running on the full-rate clock.
// Samples the lanes when the phase counter is 0. Alternate edges (the divide-by-two
// enable) load the half-rate pair, and every edge picks one of the pair.
// Assumes the lanes are steady across the sampling edge. A valid flag goes with the data.
module ffe_lane_serializer
    import ffe_tx_pkg::*;
#(
    parameter int NL = N_LANES,
    localparam int PH_W = $clog2(NL),
    localparam int HALF = NL / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] lanes,
    output logic          ser_bit,
    output logic          ser_vld
);

    logic [PH_W-1:0] phase_q;
    logic [NL-1:0]   grp_q;
    logic            grp_v_q;
    logic [HALF-1:0] half_q;
    logic [HALF-1:0] half_nxt;
    logic            half_v_q;
    logic            half_en;

    assign half_en = phase_q[0];

    // 4:2 selection: even stream takes lanes 0/2, odd stream takes lanes 1/3.
    generate
        for (genvar s = 0; s < HALF; s++) begin : g_half
            assign half_nxt[s] = phase_q[1] ? grp_q[HALF + s] : grp_q[s];
        end
    endgenerate

    // Phase counter: free-running bit-time count inside a lane group.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end

    // Quarter-rate capture of the parallel lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q   <= '0;
            grp_v_q <= 1'b0;
        end else if (phase_q == '0) begin
            grp_q   <= lanes;
            grp_v_q <= 1'b1;
        end
    end

    // Half-rate pair register, loaded on the divide-by-two enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q   <= '0;
            half_v_q <= 1'b0;
        end else if (half_en) begin
            half_q   <= half_nxt;
            half_v_q <= grp_v_q;
        end
    end

    // 2:1 stage: even stream on even phases, odd stream on odd phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_bit <= 1'b0;
            ser_vld <= 1'b0;
        end else begin
            ser_bit <= half_en ? half_q[1] : half_q[0];
            ser_vld <= half_v_q;
        end
    end

    // R2
    first_bit_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_vld) |-> phase_q == PH_W'(3));

endmodule

// File: rtl/ffe_tap_sum.sv
// Module: bit history and signed four-tap sum.
// The incoming serial bit is the precursor. Three registers hold the main and two
// postcursor bits. The registered code is zero until every tap sees a valid bit.
module ffe_tap_sum
    import ffe_tx_pkg::*;
#(
    parameter int NT = N_TAPS,
    parameter int MW = MAG_W,
    parameter int CW = CODE_W,
    localparam int NH = NT - 1,
    localparam int LIM = NT * ((1 << MW) - 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_bit,
    input  logic                 ser_vld,
    input  tap_w_t               taps [NT],
    output logic signed [CW-1:0] code
);

    logic [NH-1:0]        hist_q;
    logic [NH-1:0]        hist_v_q;
    logic [NT-1:0]        tap_bit;
    logic signed [CW-1:0] term [NT];
    logic signed [CW-1:0] total;
    logic                 full;

    assign tap_bit = {hist_q, ser_bit};
    assign full    = ser_vld & (&hist_v_q);

    // Per-tap contribution: +magnitude when bit XOR inversion is one.
    generate
        for (genvar t = 0; t < NT; t++) begin : g_term
            logic signed [CW-1:0] mag_ext;
            assign mag_ext = $signed({{(CW-MW){1'b0}}, taps[t].mag});
            assign term[t] = (tap_bit[t] ^ taps[t].inv) ? mag_ext : -mag_ext;
        end
    endgenerate

    // Adder: sums the four signed contributions.
    always_comb begin
        total = '0;
        for (int t = 0; t < NT; t++) total = total + term[t];
    end

    // History: shifts the serial bit and its valid flag along the taps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q   <= '0;
            hist_v_q <= '0;
        end else begin
            hist_q   <= {hist_q[NH-2:0], ser_bit};
            hist_v_q <= {hist_v_q[NH-2:0], ser_vld};
        end
    end

    // Output register: held at zero until the history is full.
    always_ff @(posedge clk) begin
        if (!rst_n) code <= '0;
        else        code <= full ? total : '0;
    end

    // R9
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code <= CW'(LIM)) && (code >= -CW'(LIM)));

    // R8
    code_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code != '0) |-> $past(ser_vld));

endmodule

// File: rtl/ffe_tx_serializer.sv
// Module (top): quarter-rate four-lane serializer with a four-tap transmit equalizer.
// Power-down from the configuration port holds the datapath cleared. Releasing it
// restarts the serializer at lane-group phase 0. One clock domain: the bit clock.
module ffe_tx_serializer
    import ffe_tx_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_LANES-1:0]       lane_i,
    input  logic                     cfg_shift_i,
    input  logic                     cfg_sdi_i,
    input  logic                     cfg_load_i,
    output logic signed [CODE_W-1:0] eq_code_o
);

    tap_w_t taps [N_TAPS];
    logic   pd;
    logic   pipe_rst_n;
    logic   ser_bit;
    logic   ser_vld;

    assign pipe_rst_n = rst_n & ~pd;

    ffe_cfg_port #(.NT(N_TAPS), .FW(FIELD_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift_i),
        .sdi      (cfg_sdi_i),
        .load     (cfg_load_i),
        .taps     (taps),
        .pd       (pd)
    );

    ffe_lane_serializer #(.NL(N_LANES)) u_ser (
        .clk     (clk),
        .rst_n   (pipe_rst_n),
        .lanes   (lane_i),
        .ser_bit (ser_bit),
        .ser_vld (ser_vld)
    );

    ffe_tap_sum #(.NT(N_TAPS), .MW(MAG_W), .CW(CODE_W)) u_sum (
        .clk     (clk),
        .rst_n   (pipe_rst_n),
        .ser_bit (ser_bit),
        .ser_vld (ser_vld),
        .taps    (taps),
        .code    (eq_code_o)
    );

    // R7
    pd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd |=> eq_code_o == '0);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> eq_code_o == '0);

endmodule

// File: tb/ffe_tx_serializer_tb.sv
// Bench: directed scenarios, one task each, with a bench-side model of the taps.
module ffe_tx_serializer_tb;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        lane_i = 4'h0;
    logic              cfg_shift_i = 1'b0;
    logic              cfg_sdi_i = 1'b0;
    logic              cfg_load_i = 1'b0;
    logic signed [8:0] eq_code_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    int         m_mag [4];
    bit         m_inv [4];
    logic [3:0] grps  [16];

    always #4ns clk = ~clk;

    ffe_tx_serializer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .lane_i      (lane_i),
        .cfg_shift_i (cfg_shift_i),
        .cfg_sdi_i   (cfg_sdi_i),
        .cfg_load_i  (cfg_load_i),
        .eq_code_o   (eq_code_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model(input bit pre, input bit cur, input bit p1, input bit p2);
        bit b [4];
        int s = 0;
        b[0] = pre; b[1] = cur; b[2] = p1; b[3] = p2;
        for (int t = 0; t < 4; t++) s += (b[t] ^ m_inv[t]) ? m_mag[t] : -m_mag[t];
        return s;
    endfunction

    function automatic logic [28:0] mk_word(input bit pd);
        logic [28:0] w;
        w[28] = pd;
        for (int t = 0; t < 4; t++) w[27 - 7*t -: 7] = {m_inv[t], 6'(m_mag[t])};
        return w;
    endfunction

    function automatic bit sbit(input int n);
        return grps[n / 4][n % 4];
    endfunction

    // Shifts a word in; optionally holds a constant-output check and applies it.
    task automatic cfg_send(input logic [28:0] w, input bit do_load,
                            input bit chk_const, input int exp, input string req);
        for (int i = 28; i >= 0; i--) begin
            cfg_shift_i = 1'b1;
            cfg_sdi_i   = w[i];
            @(negedge clk);
            if (chk_const) check(req, eq_code_o, exp);
        end
        cfg_shift_i = 1'b0;
        if (do_load) begin
            cfg_load_i = 1'b1;
            @(negedge clk);
            cfg_load_i = 1'b0;
        end
    endtask

    // Loads the model taps with power-down on, then off, to restart the pipeline.
    task automatic apply_taps();
        cfg_send(mk_word(1'b1), 1'b1, 1'b0, 0, "");
        cfg_send(mk_word(1'b0), 1'b1, 1'b0, 0, "");
    endtask

    // Streams ngr groups from a restart; checks every code against the model.
    task automatic stream(input int ngr, input string req);
        int nb = 4 * ngr;
        for (int k = 0; k < nb + 4; k++) begin
            if (k % 4 == 0 && k / 4 < ngr) lane_i = grps[k / 4];
            @(negedge clk);
            if (k < 6) check({req, "/R8"}, eq_code_o, 0);
            else if (k - 3 < nb)
                check(req, eq_code_o, model(sbit(k-3), sbit(k-4), sbit(k-5), sbit(k-6)));
        end
    endtask

    task automatic set_taps(input int a, input bit ai, input int b, input bit bi,
                            input int c, input bit ci, input int d, input bit di);
        m_mag[0] = a; m_inv[0] = ai; m_mag[1] = b; m_inv[1] = bi;
        m_mag[2] = c; m_inv[2] = ci; m_mag[3] = d; m_inv[3] = di;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset code", eq_code_o, 0);
        rst_n = 1'b1;
        set_taps(0, 0, 63, 0, 0, 0, 0, 0);
    endtask

    // R1, R2, R8: default weights, lane order visible as +-63 per bit.
    task automatic t_default();
        do_reset();
        grps[0] = 4'b0001; grps[1] = 4'b0110; grps[2] = 4'b1011; grps[3] = 4'b1000;
        grps[4] = 4'b1111; grps[5] = 4'b0100;
        stream(6, "R1/R2 default");
    endtask

    // R3, R4: all four taps, mixed inversion flags.
    task automatic t_taps();
        set_taps(10, 0, 40, 0, 15, 1, 5, 1);
        apply_taps();
        grps[0] = 4'b1101; grps[1] = 4'b0010; grps[2] = 4'b0111; grps[3] = 4'b1001;
        grps[4] = 4'b0011; grps[5] = 4'b1100; grps[6] = 4'b0101;
        stream(7, "R3 taps");
        set_taps(20, 1, 33, 1, 7, 0, 12, 0);
        apply_taps();
        stream(7, "R4 inversion");
    endtask

    // R5: main plus inverted first postcursor; explicit repeat/differ values.
    task automatic t_one_tap();
        set_taps(0, 0, 30, 0, 20, 1, 0, 0);
        apply_taps();
        grps[0] = 4'b1100; grps[1] = 4'b1100; grps[2] = 4'b0011; grps[3] = 4'b0011;
        stream(4, "R5 deemph");
        grps[0] = 4'b1111; grps[1] = 4'b1111;
        lane_i = grps[0];
        repeat (12) @(negedge clk);
        check("R5 repeat ones", eq_code_o, 10);
        grps[0] = 4'b0101; grps[1] = 4'b0101; grps[2] = 4'b0101;
        apply_taps();
        stream(3, "R5 toggle");
        repeat (10) @(negedge clk);
        check("R5 differ", (eq_code_o < 0) ? -eq_code_o : eq_code_o, 50);
    endtask

    // R9: extremes of the 9-bit code.
    task automatic t_extremes();
        set_taps(63, 0, 63, 0, 63, 0, 63, 0);
        apply_taps();
        grps[0] = 4'hF; grps[1] = 4'hF; grps[2] = 4'hF;
        stream(3, "R9 max");
        check("R9 +252", eq_code_o, 252);
        grps[0] = 4'h0; grps[1] = 4'h0; grps[2] = 4'h0;
        apply_taps();
        stream(3, "R9 min");
        check("R9 -252", eq_code_o, -252);
    endtask

    // R6: shifting without load leaves the output unchanged; load then applies.
    task automatic t_no_load();
        logic [28:0] w;
        set_taps(3, 0, 25, 0, 9, 0, 0, 0);
        apply_taps();
        grps[0] = 4'hF; grps[1] = 4'hF; grps[2] = 4'hF;
        stream(3, "R6 base");
        set_taps(0, 0, 11, 0, 0, 0, 0, 0);
        w = mk_word(1'b0);
        cfg_send(w, 1'b0, 1'b1, 37, "R6 no load");
        repeat (3) @(negedge clk);
        check("R6 still old", eq_code_o, 37);
        cfg_load_i = 1'b1;
        @(negedge clk);
        cfg_load_i = 1'b0;
        @(negedge clk);
        check("R6 applied", eq_code_o, 11);
    endtask

    // R7: power-down zeroes the output, then the restart timing matches reset.
    task automatic t_power_down();
        set_taps(5, 0, 50, 0, 8, 1, 0, 0);
        cfg_send(mk_word(1'b1), 1'b1, 1'b0, 0, "");
        for (int i = 0; i < 12; i++) begin
            lane_i = 4'(i * 5 + 3);
            @(negedge clk);
            check("R7 pd zero", eq_code_o, 0);
        end
        cfg_send(mk_word(1'b0), 1'b1, 1'b0, 0, "");
        grps[0] = 4'b1010; grps[1] = 4'b0110; grps[2] = 4'b1101; grps[3] = 4'b0001;
        stream(4, "R7 restart");
    endtask

    // R1: reset restores the default weights after other settings.
    task automatic t_reset_again();
        do_reset();
        grps[0] = 4'b1001; grps[1] = 4'b0111; grps[2] = 4'b1110;
        stream(3, "R1 defaults back");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_default();
        t_taps();
        t_one_tap();
        t_extremes();
        t_no_load();
        t_power_down();
        t_reset_again();
        finish_run();
    end

    initial begin
        #400us;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule